// File: doc/BRIEF.md
# Gated-Operand Add/Subtract ALU

This block is a 16-bit arithmetic unit for a small accumulator-style datapath. Every one of its functions comes from a single ripple-carry adder. A control stage sets three things: whether operand A reaches the adder, whether operand B goes in true or inverted, and what the carry-in is. This gives A+B, A-B, a plain pass of B, and B+1. The last of these is the usual way such a datapath steps its program counter without a separate incrementer.

A reset input overrides the function select. While it is active, both operands and the carry-in are forced to zero, so the adder produces zero. The block holds no state and uses no clock. The result and the carry-out follow the inputs within the same evaluation.

Top module: `gated_alu`

## Requirements
- R1: With `fn` = 2'b00 and `rst` low, `result` is (A+B) mod 2^16 and `carry_out` is bit 16 of the 17-bit unsigned sum.
- R2: With `fn` = 2'b01 and `rst` low, `result` is (A-B) mod 2^16. It is formed as A plus the inverse of B plus a carry-in of 1. `carry_out` is 1 exactly when A >= B taken as unsigned.
- R3: With `fn` = 2'b10 and `rst` low, `result` equals B and `carry_out` is 0.
- R4: With `fn` = 2'b11 and `rst` low, `result` is (B+1) mod 2^16. `carry_out` is 1 only when B is 16'hFFFF.
- R5: While `rst` is high, `result` is 0 and `carry_out` is 0, whatever the values of A, B and `fn`.
- R6: With `fn` = 2'b10 or 2'b11 and `rst` low, operand A has no effect on `result` or `carry_out`.
- R7: The block is purely combinational. A change on any input shows on the outputs with no clock edge.
- R8: Subtracting equal operands gives a `result` of 0 with `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | Operand A; it reaches the adder only in the add and subtract functions |
| b | input | 16 | Operand B |
| fn | input | 2 | Function select: 00 add, 01 subtract, 10 pass B, 11 increment B |
| rst | input | 1 | Forces a zero result and a zero carry while high |
| result | output | 16 | Adder sum |
| carry_out | output | 1 | Carry out of the most significant adder bit |

## Verification
The hardest cases to reach from the ports are those where the carry ripples through all sixteen bits. Two examples are incrementing 16'hFFFF and subtracting equal operands, where the inverted B and the carry-in together cause a full wrap. Uniform random operands almost never produce these. The stimulus therefore adds directed vectors with all-ones, zero and equal operands, and it biases part of the random set toward operands drawn from the extremes. The bench also shows that A is gated off by sweeping A while B and the select are held fixed, then comparing the outputs.

// File: rtl/gated_alu_pkg.sv
package gated_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_PASS = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic b_inv;
    logic cin;
  } alu_ctl_t;

  // Maps the select and the reset onto the adder's control terms.
  function automatic alu_ctl_t decode_fn(input alu_fn_e fn, input logic rst);
    alu_ctl_t c;
    c = '0;
    if (!rst) begin
      c.b_en = 1'b1;
      unique case (fn)
        FN_ADD:  begin c.a_en = 1'b1; c.b_inv = 1'b0; c.cin = 1'b0; end
        FN_SUB:  begin c.a_en = 1'b1; c.b_inv = 1'b1; c.cin = 1'b1; end
        FN_PASS: begin c.a_en = 1'b0; c.b_inv = 1'b0; c.cin = 1'b0; end
        FN_INC:  begin c.a_en = 1'b0; c.b_inv = 1'b0; c.cin = 1'b1; end
        default: c = '0;
      endcase
    end
    return c;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/gated_alu_ctrl.sv
module gated_alu_ctrl
  import gated_alu_pkg::*;
(
  input  logic [1:0] fn,
  input  logic       rst,
  output logic       a_en,
  output logic       b_en,
  output logic       b_inv,
  output logic       cin
);
  alu_ctl_t ctl;

  always_comb begin
    ctl   = decode_fn(alu_fn_e'(fn), rst);
    a_en  = ctl.a_en;
    b_en  = ctl.b_en;
    b_inv = ctl.b_inv;
    cin   = ctl.cin;
  end

  always_comb begin
    if (rst) AST_CTRL_RESET_QUIET: assert (!a_en && !b_en && !cin); // R5
  end
endmodule

// File: rtl/gated_alu_operand.sv
module gated_alu_operand #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_en,
  input  logic         b_en,
  input  logic         b_inv,
  output logic [W-1:0] a_op,
  output logic [W-1:0] b_op
);
  logic [W-1:0] b_gated;

  always_comb begin
    a_op    = a & {W{a_en}};
    b_gated = b & {W{b_en}};
    b_op    = b_gated ^ {W{b_inv}};
  end

  always_comb begin
    if (!a_en) AST_A_GATED_OFF: assert (a_op == '0); // R6
  end
endmodule

// File: rtl/gated_alu_adder.sv
module gated_alu_adder
  import gated_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int CW = W + 1;

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
  end

  assign cout = chain[W];

  always_comb begin
    AST_CHAIN_MATCHES_SUM: assert ({cout, sum} ==
      (CW'(x) + CW'(y) + CW'(cin))); // R1
  end
endmodule

// File: rtl/gated_alu.sv
module gated_alu
  import gated_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  input  logic         rst,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic         a_en, b_en, b_inv, cin;
  logic [W-1:0] a_op, b_op;

  gated_alu_ctrl u_ctrl (
    .fn    (fn),
    .rst   (rst),
    .a_en  (a_en),
    .b_en  (b_en),
    .b_inv (b_inv),
    .cin   (cin)
  );

  gated_alu_operand #(.W(W)) u_operand (
    .a     (a),
    .b     (b),
    .a_en  (a_en),
    .b_en  (b_en),
    .b_inv (b_inv),
    .a_op  (a_op),
    .b_op  (b_op)
  );

  gated_alu_adder #(.W(W)) u_adder (
    .x    (a_op),
    .y    (b_op),
    .cin  (cin),
    .sum  (result),
    .cout (carry_out)
  );

  always_comb begin
    if (rst) AST_RESET_ZERO: assert (result == '0 && !carry_out); // R5
    if (!rst && fn == FN_PASS) AST_PASS_B: assert (result == b && !carry_out); // R3
    if (!rst && fn == FN_INC) AST_INC_CARRY: assert (carry_out == (b == '1)); // R4
    if (!rst && fn == FN_SUB) AST_SUB_NO_BORROW: assert (carry_out == (a >= b)); // R2
  end
endmodule

// File: tb/test_gated_alu.sv
module test_gated_alu;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, result;
  logic [1:0]   fn;
  logic         rst, carry_out;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  gated_alu #(.W(W)) i_gated_alu (
    .a(a), .b(b), .fn(fn), .rst(rst), .result(result), .carry_out(carry_out)
  );

  // Expected {carry, result}, written from the requirements.
  function automatic logic [W:0] model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                       input logic [1:0] f, input logic r);
    logic [W:0] o;
    if (r) return '0;
    case (f)
      2'b00: o = {1'b0, av} + {1'b0, bv};
      2'b01: begin o[W-1:0] = av - bv; o[W] = (av >= bv); end
      2'b10: o = {1'b0, bv};
      default: begin o[W-1:0] = bv + 1'b1; o[W] = (bv == '1); end
    endcase
    return o;
  endfunction

  function automatic string tag_of(input logic [1:0] f, input logic r);
    if (r) return "R5";
    case (f)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [W:0] exp);
    checks++;
    if ({carry_out, result} !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h fn=%b rst=%b got c=%b r=%h exp c=%b r=%h",
               tag, a, b, fn, rst, carry_out, result, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic [1:0] f, input logic r, input string tag);
    @(posedge clk);
    a = av; b = bv; fn = f; rst = r;
    @(negedge clk);
    compare(tag, model(av, bv, f, r));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ref_r;
    logic         ref_c;
    void'($urandom(32'd4242));
    a = 16'h1234; b = 16'h5678; fn = 2'b00; rst = 1'b1;
    @(negedge clk);
    compare("R5", '0);

    // Reset overrides every select.
    for (int f = 0; f < 4; f++) apply(16'hFFFF, 16'hFFFF, 2'(f), 1'b1, "R5");

    // Directed corners.
    apply(16'hFFFF, 16'h0001, 2'b00, 1'b0, "R1");
    apply(16'h8000, 16'h8000, 2'b00, 1'b0, "R1");
    apply(16'h0000, 16'h0000, 2'b00, 1'b0, "R1");
    apply(16'h0000, 16'h0001, 2'b01, 1'b0, "R2");
    apply(16'h0000, 16'h0000, 2'b01, 1'b0, "R8");
    apply(16'hBEEF, 16'hBEEF, 2'b01, 1'b0, "R8");
    apply(16'hFFFF, 16'h0000, 2'b01, 1'b0, "R2");
    apply(16'hAAAA, 16'h5555, 2'b10, 1'b0, "R3");
    apply(16'h1234, 16'hFFFF, 2'b11, 1'b0, "R4");
    apply(16'h1234, 16'h7FFF, 2'b11, 1'b0, "R4");

    // R6: sweep A with B and select fixed.
    for (int f = 2; f < 4; f++) begin
      apply(16'h0000, 16'h3C3C, 2'(f), 1'b0, "R6");
      ref_r = result; ref_c = carry_out;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk);
        a = 16'($urandom());
        @(negedge clk);
        checks++;
        if (result !== ref_r || carry_out !== ref_c) begin
          failures++;
          $display("FAIL R6 a=%h got c=%b r=%h exp c=%b r=%h",
                   a, carry_out, result, ref_c, ref_r);
        end
      end
    end

    // R7: outputs follow inputs between clock edges.
    @(posedge clk);
    #3 a = 16'h0010; b = 16'h0020; fn = 2'b00; rst = 1'b0;
    #1 compare("R7", model(a, b, fn, rst));
    #1 fn = 2'b01;
    #1 compare("R7", model(a, b, fn, rst));
    #1 rst = 1'b1;
    #1 compare("R7", model(a, b, fn, rst));

    // Random stimulus, partly biased toward extreme operands.
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] av, bv;
      logic [1:0]   f;
      logic         r;
      av = 16'($urandom());
      bv = 16'($urandom());
      if ($urandom_range(3) == 0) av = $urandom_range(1) ? '1 : '0;
      if ($urandom_range(3) == 0) bv = $urandom_range(1) ? '1 : av;
      f = 2'($urandom_range(3));
      r = ($urandom_range(15) == 0);
      apply(av, bv, f, r, tag_of(f, r));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule